// File: doc/BRIEF.md
# Vertical Sync Selector and Width Regenerator

This block takes two raw vertical sync candidates: one from a dedicated input pin and one from a sync separator. It picks one of them and converts it to an active-high internal pulse, whatever its incoming polarity. It then drives a vertical sync output whose asserted level is programmable. The source can be chosen automatically or forced by configuration. The input polarity can be learned from the signal itself or forced as well.

An optional duration mode replaces the width of the incoming pulse. In that mode the output asserts on the leading edge of the normalised input and stays asserted for a programmed number of horizontal sync strobes. Any input activity inside that window is ignored. Duration mode only takes effect while the filter gate is enabled, because the two are meant to be used together. With either bit clear, the normalised input width passes straight through.

Top module: `vsync_regen`

## Requirements
- R1: With `src_ovr` = 1, `src_sel` = 0 selects the pin input and `src_sel` = 1 selects the separator input.
- R2: With `src_ovr` = 0, the pin input is used when its sampled value has changed within the last `FRAME_CYC` clocks; otherwise the separator input is used. After reset the separator is used until the pin toggles.
- R3: With `pol_ovr` = 1, `pol_in` = 1 treats the selected input as active-high and `pol_in` = 0 treats it as active-low.
- R4: With `pol_ovr` = 0, the idle level is learned once the selected sampled input has held one value on `HOLD_CYC`+1 consecutive clocks, and the active level is the opposite of the idle level. Before any level has been learned the input is treated as active-high.
- R5: `out_pol` = 1 makes `vs_out` high while asserted; `out_pol` = 0 makes it low while asserted.
- R6: When `dur_en` = 0 or `filt_en` = 0, `vs_out` follows the normalised selected input with a latency of two clock edges.
- R7: When `dur_en` = 1 and `filt_en` = 1, a rising edge of the normalised input asserts `vs_out` with the same two-edge latency as R6.
- R8: In duration mode, `vs_out` deasserts on the clock edge that samples the `dur_count`-th `hs_strobe` after the asserting edge. A strobe sampled on the asserting edge is not counted, `dur_count` = 0 behaves as 1, and input edges during the window are ignored.
- R9: While `rst` is high, `vs_out` is 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Pixel clock |
| rst | input | 1 | Synchronous active-high reset |
| hs_strobe | input | 1 | One-clock pulse per horizontal sync period |
| vs_pin | input | 1 | Raw vertical sync from the dedicated pin |
| vs_sep | input | 1 | Raw vertical sync from the sync separator |
| src_ovr | input | 1 | 1 = source forced by `src_sel` |
| src_sel | input | 1 | Forced source: 0 pin, 1 separator |
| pol_ovr | input | 1 | 1 = input polarity forced by `pol_in` |
| pol_in | input | 1 | Forced input polarity: 1 positive, 0 negative |
| out_pol | input | 1 | Output asserted level: 1 high, 0 low |
| filt_en | input | 1 | Filter gate; duration mode needs it set |
| dur_en | input | 1 | Duration mode enable |
| dur_count | input | DUR_W | Number of strobes the regenerated pulse lasts |
| vs_out | output | 1 | Regenerated vertical sync |

## Verification
A change on either raw input shows at `vs_out` two clock edges later: one edge for the input sampling register and one for the output register. A strobe that ends a duration window takes effect on the very edge that samples it. The reference model in the bench advances once per rising edge, from the inputs driven at the preceding falling edge. `vs_out` is compared against it at every falling edge, so each result is checked in the exact cycle it is due and never one cycle early or late. The source choice falls back to the separator `FRAME_CYC` clocks after the pin goes quiet, and the idle level is learned after `HOLD_CYC`+1 clocks. Both effects appear in the same comparison, at the cycle where the model's counters reach their limits.

// File: rtl/vsync_regen_pkg.sv
package vsync_regen_pkg;

  typedef enum logic {
    SRC_PIN = 1'b0,
    SRC_SEP = 1'b1
  } vs_src_e;

  // Map a level to its active-high form given the asserted level.
  function automatic logic to_level(input logic v, input logic active_hi);
    return active_hi ? v : ~v;
  endfunction

endpackage

// File: rtl/vsr_src_pick.sv
module vsr_src_pick #(
  parameter int FRAME_CYC = 200
) (
  input  logic clk,
  input  logic rst,
  input  logic vs_pin,
  input  logic vs_sep,
  input  logic src_ovr,
  input  logic src_sel,
  output logic raw,
  output logic use_sep
);
  import vsync_regen_pkg::*;

  localparam int AW = $clog2(FRAME_CYC + 1);
  localparam logic [AW-1:0] AGE_MAX = AW'(FRAME_CYC);

  logic          pin_q, sep_q, pin_prev;
  logic [AW-1:0] age;
  logic          pin_alive;
  vs_src_e       src;

  assign pin_alive = (age < AGE_MAX);
  assign src       = src_ovr ? vs_src_e'(src_sel)
                             : (pin_alive ? SRC_PIN : SRC_SEP);
  assign use_sep   = (src == SRC_SEP);
  assign raw       = use_sep ? sep_q : pin_q;

  always_ff @(posedge clk) begin
    if (rst) begin
      pin_q    <= 1'b0;
      sep_q    <= 1'b0;
      pin_prev <= 1'b0;
      age      <= AGE_MAX;
    end else begin
      pin_q    <= vs_pin;
      sep_q    <= vs_sep;
      pin_prev <= pin_q;
      if (pin_q != pin_prev)
        age <= '0;
      else if (age < AGE_MAX)
        age <= age + 1'b1;
    end
  end
endmodule

// File: rtl/vsr_pol_learn.sv
module vsr_pol_learn #(
  parameter int HOLD_CYC = 32
) (
  input  logic clk,
  input  logic rst,
  input  logic raw,
  input  logic pol_ovr,
  input  logic pol_in,
  output logic norm
);
  import vsync_regen_pkg::*;

  localparam int RW = $clog2(HOLD_CYC + 1);
  localparam logic [RW-1:0] RUN_MAX = RW'(HOLD_CYC);

  logic          last_v;
  logic [RW-1:0] run;
  logic          idle_lvl;
  logic          active_hi;

  assign active_hi = pol_ovr ? pol_in : ~idle_lvl;
  assign norm      = to_level(raw, active_hi);

  always_ff @(posedge clk) begin
    if (rst) begin
      last_v   <= 1'b0;
      run      <= '0;
      idle_lvl <= 1'b0;
    end else if (raw != last_v) begin
      last_v <= raw;
      run    <= '0;
    end else if (run < RUN_MAX) begin
      run <= run + 1'b1;
      if (run == RUN_MAX - 1'b1)
        idle_lvl <= raw;
    end
  end
endmodule

// File: rtl/vsr_width_gen.sv
module vsr_width_gen #(
  parameter int DUR_W = 8
) (
  input  logic             clk,
  input  logic             rst,
  input  logic             norm,
  input  logic             hs_strobe,
  input  logic             dur_en,
  input  logic             filt_en,
  input  logic             out_pol,
  input  logic [DUR_W-1:0] dur_count,
  output logic             vs_out,
  output logic             busy,
  output logic             norm_d
);
  import vsync_regen_pkg::*;

  logic             dur_mode;
  logic             rise;
  logic             busy_nx;
  logic [DUR_W-1:0] hcnt, hcnt_nx;
  logic [DUR_W:0]   hcnt_inc;

  assign dur_mode = dur_en & filt_en;
  assign rise     = norm & ~norm_d;
  assign hcnt_inc = {1'b0, hcnt} + 1'b1;

  always_comb begin
    busy_nx = busy;
    hcnt_nx = hcnt;
    if (!dur_mode) begin
      busy_nx = 1'b0;
      hcnt_nx = '0;
    end else if (!busy) begin
      if (rise) begin
        busy_nx = 1'b1;
        hcnt_nx = '0;
      end
    end else if (hs_strobe) begin
      if (hcnt_inc >= {1'b0, dur_count})
        busy_nx = 1'b0;
      else
        hcnt_nx = hcnt_inc[DUR_W-1:0];
    end
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      busy   <= 1'b0;
      hcnt   <= '0;
      norm_d <= 1'b0;
      vs_out <= 1'b0;
    end else begin
      busy   <= busy_nx;
      hcnt   <= hcnt_nx;
      norm_d <= norm;
      vs_out <= to_level(dur_mode ? busy_nx : norm, out_pol);
    end
  end
endmodule

// File: rtl/vsync_regen.sv
module vsync_regen #(
  parameter int FRAME_CYC = 200,
  parameter int HOLD_CYC  = 32,
  parameter int DUR_W     = 8
) (
  input  logic             clk,
  input  logic             rst,
  input  logic             hs_strobe,
  input  logic             vs_pin,
  input  logic             vs_sep,
  input  logic             src_ovr,
  input  logic             src_sel,
  input  logic             pol_ovr,
  input  logic             pol_in,
  input  logic             out_pol,
  input  logic             filt_en,
  input  logic             dur_en,
  input  logic [DUR_W-1:0] dur_count,
  output logic             vs_out
);
  logic raw, use_sep, norm, norm_d, busy;

  vsr_src_pick #(.FRAME_CYC(FRAME_CYC)) u_src (
    .clk(clk), .rst(rst), .vs_pin(vs_pin), .vs_sep(vs_sep),
    .src_ovr(src_ovr), .src_sel(src_sel), .raw(raw), .use_sep(use_sep)
  );

  vsr_pol_learn #(.HOLD_CYC(HOLD_CYC)) u_pol (
    .clk(clk), .rst(rst), .raw(raw), .pol_ovr(pol_ovr),
    .pol_in(pol_in), .norm(norm)
  );

  vsr_width_gen #(.DUR_W(DUR_W)) u_wid (
    .clk(clk), .rst(rst), .norm(norm), .hs_strobe(hs_strobe),
    .dur_en(dur_en), .filt_en(filt_en), .out_pol(out_pol),
    .dur_count(dur_count), .vs_out(vs_out), .busy(busy), .norm_d(norm_d)
  );
endmodule

// File: rtl/vsync_regen_chk.sv
module vsync_regen_chk (
  input logic clk,
  input logic rst,
  input logic hs_strobe,
  input logic vs_pin,
  input logic src_ovr,
  input logic out_pol,
  input logic filt_en,
  input logic dur_en,
  input logic vs_out,
  input logic use_sep,
  input logic norm,
  input logic norm_d,
  input logic busy
);
  // R2: a pin toggle makes the pin the automatic source two edges later
  a_r2_pin_alive: assert property (@(posedge clk) disable iff (rst)
    !$stable(vs_pin) |=> ##1 (src_ovr || !use_sep));

  // R6: pass-through follows the normalised input one edge later
  a_r6_passthru: assert property (@(posedge clk) disable iff (rst)
    (!dur_en || !filt_en) |=>
      (vs_out == ($past(out_pol) ? $past(norm) : !$past(norm))));

  // R7: a leading edge starts the window
  a_r7_start: assert property (@(posedge clk) disable iff (rst)
    (dur_en && filt_en && !busy && norm && !norm_d) |=> busy);

  // R8: without a strobe the window cannot close, whatever the input does
  a_r8_hold: assert property (@(posedge clk) disable iff (rst)
    (dur_en && filt_en && busy && !hs_strobe) |=> busy);

  // R5 / R8: output level tracks the window under the programmed polarity
  a_r5_level: assert property (@(posedge clk) disable iff (rst)
    (dur_en && filt_en) |=> (vs_out == ($past(out_pol) ? busy : !busy)));
endmodule

bind vsync_regen vsync_regen_chk u_chk (
  .clk(clk), .rst(rst), .hs_strobe(hs_strobe), .vs_pin(vs_pin),
  .src_ovr(src_ovr), .out_pol(out_pol), .filt_en(filt_en),
  .dur_en(dur_en), .vs_out(vs_out), .use_sep(use_sep), .norm(norm),
  .norm_d(norm_d), .busy(busy)
);

// File: tb/vsync_regen_bench.sv
module vsync_regen_bench;
  localparam int CLK_PERIOD = 10;
  localparam int FRAME = 200;
  localparam int HOLD  = 32;
  localparam int DW    = 8;
  localparam int HS_PER = 6;
  localparam int WATCHDOG = 100000;

  logic clk = 1'b0;
  logic rst = 1'b1;
  logic hs_strobe = 1'b0;
  logic vs_pin = 1'b0, vs_sep = 1'b0;
  logic src_ovr = 1'b0, src_sel = 1'b0;
  logic pol_ovr = 1'b0, pol_in = 1'b1, out_pol = 1'b1;
  logic filt_en = 1'b0, dur_en = 1'b0;
  logic [DW-1:0] dur_count = 8'd10;
  logic vs_out;

  int n_vec = 0;
  int n_bad = 0;
  string tag = "R9";
  bit done = 1'b0;

  always #(CLK_PERIOD/2) clk = ~clk;

  vsync_regen #(.FRAME_CYC(FRAME), .HOLD_CYC(HOLD), .DUR_W(DW)) u_vsync_regen (
    .clk(clk), .rst(rst), .hs_strobe(hs_strobe), .vs_pin(vs_pin),
    .vs_sep(vs_sep), .src_ovr(src_ovr), .src_sel(src_sel),
    .pol_ovr(pol_ovr), .pol_in(pol_in), .out_pol(out_pol),
    .filt_en(filt_en), .dur_en(dur_en), .dur_count(dur_count),
    .vs_out(vs_out)
  );

  // Horizontal strobe source: one clock high every HS_PER clocks
  int hs_phase = 0;
  always @(negedge clk) begin
    hs_strobe <= (hs_phase == 0);
    hs_phase  <= (hs_phase + 1) % HS_PER;
  end

  // Behavioural reference, one step per rising edge
  int m_pin, m_sep, m_pprev, m_age, m_last, m_run, m_idle, m_normd;
  int m_busy, m_cnt, m_exp;
  always @(posedge clk) begin
    if (rst) begin
      m_pin = 0; m_sep = 0; m_pprev = 0; m_age = FRAME;
      m_last = 0; m_run = 0; m_idle = 0; m_normd = 0;
      m_busy = 0; m_cnt = 0; m_exp = 0;
    end else begin
      int take_sep, level, hi, nrm, dm;
      take_sep = src_ovr ? int'(src_sel) : (m_age < FRAME ? 0 : 1);
      level = take_sep ? m_sep : m_pin;
      hi = pol_ovr ? int'(pol_in) : (m_idle ? 0 : 1);
      nrm = hi ? level : 1 - level;
      dm = dur_en && filt_en;
      if (!dm) begin
        m_busy = 0; m_cnt = 0;
      end else if (!m_busy) begin
        if (nrm == 1 && m_normd == 0) begin m_busy = 1; m_cnt = 0; end
      end else if (hs_strobe) begin
        if (m_cnt + 1 >= int'(dur_count)) m_busy = 0;
        else m_cnt = m_cnt + 1;
      end
      m_exp = dm ? m_busy : nrm;
      if (!out_pol) m_exp = 1 - m_exp;
      if (level != m_last) begin m_last = level; m_run = 0; end
      else if (m_run < HOLD) begin
        if (m_run == HOLD - 1) m_idle = level;
        m_run = m_run + 1;
      end
      if (m_pin != m_pprev) m_age = 0;
      else if (m_age < FRAME) m_age = m_age + 1;
      m_pprev = m_pin;
      m_pin = vs_pin;
      m_sep = vs_sep;
      m_normd = nrm;
    end
  end

  // Compare on every falling edge
  always @(negedge clk) begin
    if (!done) begin
      n_vec++;
      if (rst) begin
        if (vs_out !== 1'b0) begin
          n_bad++;
          $display("FAIL R9: vs_out=%0b expected 0 during reset", vs_out);
        end
      end else if (vs_out !== m_exp[0]) begin
        n_bad++;
        $display("FAIL %s at %0t: vs_out=%0b expected %0d", tag, $time, vs_out, m_exp);
      end
    end
  end

  task automatic wait_clk(input int n);
    repeat (n) @(negedge clk);
  endtask

  task automatic pin_pulse(input logic idle, input int on, input int off);
    vs_pin = !idle; wait_clk(on);
    vs_pin = idle;  wait_clk(off);
  endtask

  task automatic sep_pulse(input logic idle, input int on, input int off);
    vs_sep = !idle; wait_clk(on);
    vs_sep = idle;  wait_clk(off);
  endtask

  task automatic finish_run;
    done = 1'b1;
    $display("== %0d vectors applied, %0d miscompares ==", n_vec, n_bad);
    $finish;
  endtask

  initial begin
    repeat (WATCHDOG) @(posedge clk);
    n_bad++;
    $display("FAIL watchdog: run did not complete, expected end before %0d clocks", WATCHDOG);
    finish_run();
  end

  initial begin
    tag = "R9";
    vs_pin = 1'b1;
    wait_clk(6);
    rst = 1'b0;
    wait_clk(3);

    // R2 / R6: quiet pin falls back to separator; filter gate off keeps pass-through
    tag = "R2"; vs_pin = 1'b0; dur_en = 1'b1; filt_en = 1'b0;
    wait_clk(FRAME + 10);
    tag = "R6";
    for (int i = 0; i < 3; i++) sep_pulse(1'b0, 15 + i, 40);
    tag = "R2";
    for (int i = 0; i < 3; i++) pin_pulse(1'b0, 12, 50);
    vs_sep = 1'b1; wait_clk(30); vs_sep = 1'b0;
    wait_clk(FRAME + 20);
    for (int i = 0; i < 2; i++) sep_pulse(1'b0, 9, 30);

    // R1: forced source
    tag = "R1"; src_ovr = 1'b1; src_sel = 1'b0;
    vs_sep = 1'b1; wait_clk(20);
    for (int i = 0; i < 2; i++) pin_pulse(1'b0, 7, 25);
    src_sel = 1'b1; wait_clk(15);
    vs_sep = 1'b0; wait_clk(10);
    pin_pulse(1'b0, 8, 20);
    sep_pulse(1'b0, 11, 20);
    src_sel = 1'b0;

    // R3: forced negative input polarity
    tag = "R3"; pol_ovr = 1'b1; pol_in = 1'b0;
    vs_pin = 1'b1; wait_clk(20);
    for (int i = 0; i < 3; i++) pin_pulse(1'b1, 5 + i, 30);

    // R4: learned polarity from a high idle level
    tag = "R4"; pol_ovr = 1'b0;
    wait_clk(HOLD + 10);
    for (int i = 0; i < 3; i++) pin_pulse(1'b1, 6, HOLD + 8);
    vs_pin = 1'b0; wait_clk(HOLD + 10);
    for (int i = 0; i < 2; i++) pin_pulse(1'b0, 6, 30);

    // R5: low-asserted output
    tag = "R5"; out_pol = 1'b0;
    for (int i = 0; i < 2; i++) pin_pulse(1'b0, 9, 30);
    out_pol = 1'b1;

    // R7 / R8: duration mode, glitches inside the window ignored
    tag = "R7"; pol_ovr = 1'b1; pol_in = 1'b1; filt_en = 1'b1; dur_count = 8'd3;
    wait_clk(10);
    pin_pulse(1'b0, 4, 40);
    tag = "R8";
    pin_pulse(1'b0, 2, 2); pin_pulse(1'b0, 2, 2); pin_pulse(1'b0, 3, 40);
    pin_pulse(1'b0, 60, 40);
    dur_count = 8'd0; pin_pulse(1'b0, 5, 30);
    dur_count = 8'd1; pin_pulse(1'b0, 5, 30);
    out_pol = 1'b0; dur_count = 8'd4; pin_pulse(1'b0, 3, 50);
    out_pol = 1'b1;

    // R6: duration enable cleared restores pass-through
    tag = "R6"; dur_en = 1'b0;
    pin_pulse(1'b0, 13, 30);
    wait_clk(10);
    finish_run();
  end
endmodule